// File: doc/BRIEF.md
# Latched Serial Interrupt Status Unit

This block collects the interrupt causes of a serial port that has internal receive and transmit FIFOs. It holds three FIFO-side events in sticky bits until software acknowledges them by writing ones. The first event is a programmed byte arriving a programmed number of times in a row. The second is the receive FIFO filling past half-full, or a receive timeout. The third is the transmit FIFO draining below half-full. A fourth bit shows the serial controller's own interrupt line live, with no latch. The FIFOs, the controller and the timeout timer sit outside the block and reach it only as level and pulse inputs.

A small register bus exposes three locations. The status register is at offset 8. The pattern byte is at offset 10 and the repeat count at offset 11. Reads are combinational. Writes take effect at the next rising clock edge. A configuration input selects the internal interrupt source. When it is low, no status bit can assert and the combined interrupt output stays low.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the status register reads 0x00, both pattern registers read 0x00 and `irq` is low.
- R2: Status bit 0 always equals `scc_irq` AND `cfg_int_sel` with no latching, writes do not change it, and status bits 7 to 4 always read zero.
- R3: Status bit 1 sets at the clock edge where `tx_level` is below FIFO_DEPTH/2 while at the previous edge it was at or above FIFO_DEPTH/2. Out of reset the transmit FIFO is taken as below half, so a first falling crossing must first be preceded by a level at or above half.
- R4: Status bit 2 sets at the clock edge where `rx_level` is above FIFO_DEPTH/2 while at the previous edge it was at or below it, and also at any edge where `rx_timeout` is high.
- R5: With a nonzero count N at offset 11, status bit 3 sets at the edge of the Nth consecutive `rx_valid` byte equal to the byte at offset 10. A valid byte that does not match restarts the run from zero, cycles without `rx_valid` do not break the run, and the run restarts from zero after each hit.
- R6: A count of zero at offset 11 disables pattern detection, so bit 3 never sets.
- R7: Writing offset 8 clears each of bits 3 to 1 whose write-data bit is 1. A 0 in that position leaves the bit unchanged.
- R8: When a set event and a write-one-clear reach the same bit at the same edge, the bit ends set.
- R9: With `cfg_int_sel` low, none of bits 3 to 1 sets, bit 0 reads zero and `irq` is low.
- R10: `irq` is high exactly when `cfg_int_sel` is high and any of status bits 3 to 0 is 1.
- R11: Offsets 10 and 11 read back the last byte written to them. A write to either one restarts the match run from zero, and any byte received in that same cycle is not counted.
- R12: Bits 1 and 2 react only to crossings. An occupancy level held on one side of half-full does not set a bit again after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_int_sel | input | 1 | Selects the internal interrupt source; gates all status |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| scc_irq | input | 1 | Live interrupt from the serial controller |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_level | input | LW | Receive FIFO occupancy |
| rx_timeout | input | 1 | Receive timeout pulse |
| tx_level | input | LW | Transmit FIFO occupancy |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the one where a set event and a write-one-clear hit the same bit at the same edge. Another is a match run broken by a mismatch, by a write to a pattern register, or by a count of zero. Random stimulus seldom produces these in the right order. So directed sequences build each one on purpose: a transmit level is raised to half and then dropped in the same cycle as a clearing write, and pattern bytes are fed with a mismatch just short of the count. A long seeded random phase follows. It mixes matching and other bytes, levels crossing half-full in both directions, stray timeouts, register writes and a toggling source select. Every cycle is compared with a bench model of the status register and the interrupt output.

// File: rtl/uart_irq_status.sv
`timescale 1ns/1ps
module uart_irq_status #(
  parameter int FIFO_DEPTH = 16,
  parameter int AW = 4,
  parameter int LW = $clog2(FIFO_DEPTH + 1),
  parameter logic [AW-1:0] STAT_ADDR = AW'(8),
  parameter logic [AW-1:0] PCHR_ADDR = AW'(10),
  parameter logic [AW-1:0] PCNT_ADDR = AW'(11)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_int_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          scc_irq,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_timeout,
  input  logic [LW-1:0] tx_level,
  output logic          irq
);
  localparam int HALF = FIFO_DEPTH / 2;

  logic [3:1] stat;
  logic       tx_below_q, rx_above_q;
  logic [7:0] pat_chr, pat_cnt, run;

  wire wr_stat = bus_wr && (bus_addr == STAT_ADDR);
  wire wr_pchr = bus_wr && (bus_addr == PCHR_ADDR);
  wire wr_pcnt = bus_wr && (bus_addr == PCNT_ADDR);
  wire pat_wr  = wr_pchr || wr_pcnt;

  wire tx_below = tx_level < LW'(HALF);
  wire rx_above = rx_level > LW'(HALF);
  wire tx_evt   = tx_below && !tx_below_q;
  wire rx_evt   = (rx_above && !rx_above_q) || rx_timeout;

  wire match    = rx_valid && (rx_data == pat_chr) && (pat_cnt != 8'd0) && !pat_wr;
  wire pat_hit  = match && ((run + 8'd1) == pat_cnt);

  wire [3:1] set_v = {pat_hit, rx_evt, tx_evt} & {3{cfg_int_sel}};
  wire [3:1] clr_v = wr_stat ? bus_wdata[3:1] : 3'b000;
  wire       scc_bit = scc_irq && cfg_int_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat       <= '0;
      tx_below_q <= 1'b1;
      rx_above_q <= 1'b0;
    end else begin
      stat       <= (stat & ~clr_v) | set_v;
      tx_below_q <= tx_below;
      rx_above_q <= rx_above;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_chr <= '0;
      pat_cnt <= '0;
      run     <= '0;
    end else begin
      if (wr_pchr) pat_chr <= bus_wdata;
      if (wr_pcnt) pat_cnt <= bus_wdata;
      if (pat_wr)                run <= '0;
      else if (rx_valid) begin
        if (pat_hit)             run <= '0;
        else if (match)          run <= run + 8'd1;
        else                     run <= '0;
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == STAT_ADDR)      bus_rdata = {4'b0000, stat, scc_bit};
    else if (bus_addr == PCHR_ADDR) bus_rdata = pat_chr;
    else if (bus_addr == PCNT_ADDR) bus_rdata = pat_cnt;
  end

  assign irq = cfg_int_sel && ((|stat) || scc_irq);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(stat & ~clr_v)) == $past(stat & ~clr_v)));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && ((bus_wdata[3:1] & ~set_v) != 3'b000)) |=>
      ((stat & $past(bus_wdata[3:1] & ~set_v)) == 3'b000));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != 3'b000) |=> ((stat & $past(set_v)) == $past(set_v)));

  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_int_sel && stat == 3'b000) |=> (stat == 3'b000));

  a_r6_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_cnt == 8'd0 && !pat_wr && !stat[3]) |=> !stat[3]);

  a_r5_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_cnt != 8'd0) |-> (run < pat_cnt));
endmodule

// File: tb/sim_uart_irq_status.sv
`timescale 1ns/1ps
module sim_uart_irq_status;
  localparam int HALF = 8;
  logic clk = 0, rst_n = 0, cfg_int_sel = 1, bus_wr = 0, scc_irq = 0;
  logic rx_valid = 0, rx_timeout = 0;
  logic [3:0] bus_addr = 4'd8;
  logic [7:0] bus_wdata = 0, rx_data = 0, bus_rdata;
  logic [4:0] rx_level = 0, tx_level = 0;
  logic irq;
  int vectors = 0, miscompares = 0;

  logic [3:1] m_stat = 0;
  logic [7:0] m_pat = 0, m_n = 0;
  int m_run = 0;
  logic m_txp = 1, m_rxa = 0;

  always #4 clk = ~clk;

  uart_irq_status u0 (.clk(clk), .rst_n(rst_n), .cfg_int_sel(cfg_int_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scc_irq(scc_irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_level(rx_level), .rx_timeout(rx_timeout),
    .tx_level(tx_level), .irq(irq));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    if (bus_addr == 4'd8)  return {4'b0, m_stat, scc_irq & cfg_int_sel};
    if (bus_addr == 4'd10) return m_pat;
    if (bus_addr == 4'd11) return m_n;
    return 8'h00;
  endfunction

  task automatic model();
    logic txb, rxa, hit, pw;
    logic [3:1] setv, clrv;
    txb = tx_level < HALF;
    rxa = rx_level > HALF;
    pw = bus_wr && (bus_addr == 4'd10 || bus_addr == 4'd11);
    hit = 0;
    if (pw) m_run = 0;
    else if (rx_valid) begin
      if (m_n != 0 && rx_data == m_pat) begin
        if (m_run + 1 == int'(m_n)) begin hit = 1; m_run = 0; end
        else m_run++;
      end else m_run = 0;
    end
    if (bus_wr && bus_addr == 4'd10) m_pat = bus_wdata;
    if (bus_wr && bus_addr == 4'd11) m_n = bus_wdata;
    setv = {hit, (rxa && !m_rxa) || rx_timeout, txb && !m_txp} & {3{cfg_int_sel}};
    clrv = (bus_wr && bus_addr == 4'd8) ? bus_wdata[3:1] : 3'b000;
    m_stat = (m_stat & ~clrv) | setv;
    m_txp = txb;
    m_rxa = rxa;
  endtask

  // inputs are already driven; one clock edge, then compare at the falling edge
  task automatic step(input string req);
    model();
    @(negedge clk);
    chk(req, bus_rdata, exp_rd());
    chk(req, {7'b0, irq}, {7'b0, cfg_int_sel & ((|m_stat) | scc_irq)});
    bus_wr = 0; rx_valid = 0; rx_timeout = 0; bus_addr = 4'd8;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string req);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step(req);
  endtask

  task automatic rxb(input logic [7:0] d, input string req);
    rx_valid = 1; rx_data = d;
    step(req);
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", bus_rdata, 8'h00);
    chk("R1", {7'b0, irq}, 8'h00);
    bus_addr = 4'd10; #1 chk("R1", bus_rdata, 8'h00);
    bus_addr = 4'd11; #1 chk("R1", bus_rdata, 8'h00);
    bus_addr = 4'd8;

    wr(4'd10, 8'h5A, "R11");
    wr(4'd11, 8'd3, "R11");
    bus_addr = 4'd10; #1 chk("R11", bus_rdata, 8'h5A);
    bus_addr = 4'd11; #1 chk("R11", bus_rdata, 8'h03);
    bus_addr = 4'd8;

    scc_irq = 1; step("R2");
    chk("R2", bus_rdata, 8'h01); chk("R10", {7'b0, irq}, 8'h01);
    wr(4'd8, 8'hFF, "R2");
    chk("R2", bus_rdata, 8'h01);
    scc_irq = 0; step("R2");

    tx_level = 8; step("R3");
    tx_level = 7; step("R3");
    chk("R3", bus_rdata, 8'h02);
    wr(4'd8, 8'h02, "R7");
    chk("R7", bus_rdata, 8'h00);
    step("R12");
    chk("R12", bus_rdata, 8'h00);

    rx_level = 8; step("R4");
    rx_level = 9; step("R4");
    chk("R4", bus_rdata, 8'h04);
    wr(4'd8, 8'h00, "R7");
    chk("R7", bus_rdata, 8'h04);
    wr(4'd8, 8'h04, "R7");
    step("R12");
    chk("R12", bus_rdata, 8'h00);
    rx_timeout = 1; step("R4");
    chk("R4", bus_rdata, 8'h04);
    wr(4'd8, 8'h04, "R7");

    rxb(8'h5A, "R5"); rxb(8'h5A, "R5"); rxb(8'h11, "R5");
    rxb(8'h5A, "R5"); step("R5"); rxb(8'h5A, "R5");
    chk("R5", bus_rdata, 8'h00);
    rxb(8'h5A, "R5");
    chk("R5", bus_rdata, 8'h08);
    wr(4'd8, 8'h08, "R7");
    rxb(8'h5A, "R5"); rxb(8'h5A, "R5");
    chk("R5", bus_rdata, 8'h00);
    wr(4'd10, 8'h5A, "R11");
    rxb(8'h5A, "R11"); rxb(8'h5A, "R11");
    chk("R11", bus_rdata, 8'h00);

    wr(4'd11, 8'd0, "R6");
    repeat (5) rxb(8'h5A, "R6");
    chk("R6", bus_rdata, 8'h00);

    tx_level = 8; step("R8");
    tx_level = 7; wr(4'd8, 8'h02, "R8");
    chk("R8", bus_rdata, 8'h02);
    wr(4'd8, 8'h02, "R7");

    cfg_int_sel = 0; scc_irq = 1; tx_level = 8; step("R9");
    tx_level = 3; rx_level = 4; step("R9");
    rx_level = 12; rx_timeout = 1; step("R9");
    chk("R9", bus_rdata, 8'h00); chk("R9", {7'b0, irq}, 8'h00);
    cfg_int_sel = 1; scc_irq = 0; step("R9");
    chk("R9", bus_rdata, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 99);
      cfg_int_sel = ($urandom_range(0, 9) != 0);
      scc_irq = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) tx_level = 5'($urandom_range(0, 16));
      if ($urandom_range(0, 3) == 0) rx_level = 5'($urandom_range(0, 16));
      rx_timeout = ($urandom_range(0, 19) == 0);
      rx_valid = ($urandom_range(0, 1) == 1);
      rx_data = ($urandom_range(0, 3) != 0) ? m_pat : 8'($urandom_range(0, 255));
      if (sel < 12) begin
        bus_wr = 1; bus_addr = 4'd8; bus_wdata = 8'($urandom_range(0, 255));
      end else if (sel < 14) begin
        bus_wr = 1; bus_addr = 4'd11; bus_wdata = 8'($urandom_range(0, 4));
      end else if (sel < 15) begin
        bus_wr = 1; bus_addr = 4'd10; bus_wdata = 8'($urandom_range(0, 1) ? 8'h5A : 8'hC3);
      end else if (sel < 20) begin
        bus_addr = 4'($urandom_range(0, 15));
      end
      step("R10");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule